// File: doc/BRIEF.md
# Processor Fault Capture Register with Abort Strobe

This block gathers the fault indications of a processor bus into one 16-bit fault register. Every fault input is active low, except the bus-timeout event, which is active high. All inputs are sampled on the rising edge of the block clock, and that edge is the synchronising edge of the bus. Each source maps to fixed register bits. A set bit stays set until software reads the register and pulses the clear strobe.

Address-type faults come from two places: the external address-error input and the bus-timeout event. A cycle qualifier steers them to the I/O bit or to the memory bit. These faults, together with a generic fault on bit 0, request an instruction abort. The abort is an active-low strobe. It goes low one clock after the fault is latched and lasts exactly one clock. While a DMA or hold acknowledge is present, address faults are neither latched nor reported, and no abort is produced. The illegal-address output is held inactive during that time.

Top module: `fault_capture`

## Requirements
- R1: After reset, fault_reg is zero and both abort_n and illegal_addr_n are high.
- R2: At a clock edge, each low input sets one bit: gen_flt_n sets bit 0, dma_par_err_n sets bit 4, pio_err_n sets bit 6 and spare_flt_n sets bit 7. Bits 1-3, 9-12 and 14 are never set.
- R3: A low ext_addr_err_n sets bit 5 when mem_cycle is 0 (I/O cycle) and bit 8 when mem_cycle is 1 (memory cycle).
- R4: A high bus_tmo sets bit 5 when mem_cycle is 0 and bit 8 when mem_cycle is 1.
- R5: A low bist_flt_n sets both bit 13 and bit 15.
- R6: A set bit stays set until a clock edge at which clr is high. That edge clears every bit that is not being set at the same edge.
- R7: When a fault is being set at the same edge as clr, its bit is set after that edge.
- R8: While dma_ack_n or hold_ack_n is low, bits 5 and 8 are not set. The other sources still latch.
- R9: illegal_addr_n is low when bit 5 or bit 8 is set and neither acknowledge is low. It is high in every other case, and it follows the acknowledges in the same cycle.
- R10: When an edge sets bit 0, 5 or 8, abort_n is low for the one clock that follows the next edge. Otherwise abort_n is high.
- R11: No abort is produced if an acknowledge is low at the latching edge or at the edge that would start the abort.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Synchronising clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| gen_flt_n | input | 1 | Generic fault, sets bit 0, active low |
| dma_par_err_n | input | 1 | DMA parity error, sets bit 4, active low |
| ext_addr_err_n | input | 1 | External address error, active low |
| mem_cycle | input | 1 | Cycle qualifier: 1 memory, 0 I/O |
| pio_err_n | input | 1 | Programmed-I/O error, sets bit 6, active low |
| spare_flt_n | input | 1 | Spare fault, sets bit 7, active low |
| bist_flt_n | input | 1 | Built-in-test fault, sets bits 13 and 15, active low |
| bus_tmo | input | 1 | Bus-timeout event, active high |
| dma_ack_n | input | 1 | DMA acknowledge, active low |
| hold_ack_n | input | 1 | Hold acknowledge, active low |
| clr | input | 1 | Read-and-clear strobe |
| fault_reg | output | 16 | Sticky fault register |
| abort_n | output | 1 | Instruction-abort strobe, active low |
| illegal_addr_n | output | 1 | Illegal-address indicator, active low |

## Verification
A wrong internal state shows up at the ports in one of two ways. A stuck or wrongly mapped register bit shows at fault_reg on the clock after the stimulus. A broken abort pipeline shows as an abort that comes a clock early, a clock late, lasts two clocks, or never comes, so every abort check looks at the two clocks after the latching edge. The bench sweeps every fault source against both cycle qualifiers and all four acknowledge combinations. It also covers the corner cases: stickiness, a clear and a set at the same edge, an acknowledge that arrives only at the edge that would start the abort, and an acknowledge that arrives while an address bit is already set.

// File: rtl/fault_capture_pkg.sv
// Package: fault_capture_pkg
// Holds the register width and the fixed bit positions of each fault source.
// Assumes a 16-bit fault register. The positions are part of the behaviour
// that software decodes, so they are constants and cannot be overridden.
package fault_capture_pkg;
    localparam int FLT_W       = 16;
    localparam int POS_GEN     = 0;
    localparam int POS_DMAPAR  = 4;
    localparam int POS_IOADDR  = 5;
    localparam int POS_PIO     = 6;
    localparam int POS_SPARE   = 7;
    localparam int POS_MEMADDR = 8;
    localparam int POS_BIST_LO = 13;
    localparam int POS_BIST_HI = 15;

    // Decoded fault requests of one edge, all active high.
    typedef struct packed {
        logic gen;
        logic dma_par;
        logic addr_io;
        logic addr_mem;
        logic pio;
        logic spare;
        logic bist;
    } flt_req_t;
endpackage

// File: rtl/fc_source_map.sv
// Module: fc_source_map
// Decodes the raw fault inputs into a set vector for the fault register, and
// into an abort request. An address fault (external error or bus timeout) is
// steered by the cycle qualifier and is blocked while suspend is high.
// Assumes all inputs are synchronous to clk.
module fc_source_map
    import fault_capture_pkg::*;
#(
    parameter int W = FLT_W
) (
    input  logic         gen_flt_n,
    input  logic         dma_par_err_n,
    input  logic         ext_addr_err_n,
    input  logic         mem_cycle,
    input  logic         pio_err_n,
    input  logic         spare_flt_n,
    input  logic         bist_flt_n,
    input  logic         bus_tmo,
    input  logic         suspend,
    output logic [W-1:0] set_vec,
    output logic         abort_req
);
    flt_req_t req;
    logic     addr_hit;
    logic     addr_ok;

    // Purpose: find an address fault and apply the suspend gate.
    always_comb begin
        addr_hit = !ext_addr_err_n || bus_tmo;
        addr_ok  = addr_hit && !suspend;
    end

    // Purpose: turn the raw inputs into active-high requests.
    always_comb begin
        req.gen      = !gen_flt_n;
        req.dma_par  = !dma_par_err_n;
        req.addr_io  = addr_ok && !mem_cycle;
        req.addr_mem = addr_ok && mem_cycle;
        req.pio      = !pio_err_n;
        req.spare    = !spare_flt_n;
        req.bist     = !bist_flt_n;
    end

    // Purpose: place each request on its fixed register bits.
    always_comb begin
        set_vec              = '0;
        set_vec[POS_GEN]     = req.gen;
        set_vec[POS_DMAPAR]  = req.dma_par;
        set_vec[POS_IOADDR]  = req.addr_io;
        set_vec[POS_PIO]     = req.pio;
        set_vec[POS_SPARE]   = req.spare;
        set_vec[POS_MEMADDR] = req.addr_mem;
        set_vec[POS_BIST_LO] = req.bist;
        set_vec[POS_BIST_HI] = req.bist;
    end

    // Purpose: request an abort when bit 0, 5 or 8 is being set.
    always_comb begin
        abort_req = req.gen || req.addr_io || req.addr_mem;
    end
endmodule

// File: rtl/fc_sticky_reg.sv
// Module: fc_sticky_reg
// A register of W sticky bits. A bit is set by its set input and cleared by
// the shared clear strobe. A set at the same edge as the clear wins.
// Assumes a synchronous active-low reset.
module fc_sticky_reg #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic [W-1:0] set_vec,
    output logic [W-1:0] q
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        // Purpose: hold one fault bit until it is cleared; a set wins over the clear.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q[i] <= 1'b0;
            end else begin
                q[i] <= (q[i] && !clr) || set_vec[i];
            end
        end
    end
endmodule

// File: rtl/fc_abort_pulse.sv
// Module: fc_abort_pulse
// Two-stage pipeline. A request seen at edge k makes the strobe active for
// the clock that follows edge k+1. Suspend blocks the request at both stages.
// Assumes that the request lasts one clock per fault.
module fc_abort_pulse (
    input  logic clk,
    input  logic rst_n,
    input  logic abort_req,
    input  logic suspend,
    output logic abort_n
);
    logic pend_q;
    logic fire_q;

    // Purpose: remember a latched abort cause until the next edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else begin
            pend_q <= abort_req && !suspend;
        end
    end

    // Purpose: drive the strobe for one clock unless suspend is present now.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fire_q <= 1'b0;
        end else begin
            fire_q <= pend_q && !suspend;
        end
    end

    // Purpose: make the strobe active low.
    always_comb begin
        abort_n = !fire_q;
    end
endmodule

// File: rtl/fault_capture.sv
// Module: fault_capture (top)
// Fault capture register with abort strobe and illegal-address indicator.
// Assumes that all inputs are synchronous to clk, and that the clear strobe
// comes with the read of fault_reg.
module fault_capture
    import fault_capture_pkg::*;
#(
    parameter int FW = FLT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          gen_flt_n,
    input  logic          dma_par_err_n,
    input  logic          ext_addr_err_n,
    input  logic          mem_cycle,
    input  logic          pio_err_n,
    input  logic          spare_flt_n,
    input  logic          bist_flt_n,
    input  logic          bus_tmo,
    input  logic          dma_ack_n,
    input  logic          hold_ack_n,
    input  logic          clr,
    output logic [FW-1:0] fault_reg,
    output logic          abort_n,
    output logic          illegal_addr_n
);
    logic          suspend;
    logic [FW-1:0] set_vec;
    logic          abort_req;

    // Purpose: detect a DMA or hold acknowledge.
    always_comb begin
        suspend = !dma_ack_n || !hold_ack_n;
    end

    fc_source_map #(.W(FW)) u_map (
        .gen_flt_n      (gen_flt_n),
        .dma_par_err_n  (dma_par_err_n),
        .ext_addr_err_n (ext_addr_err_n),
        .mem_cycle      (mem_cycle),
        .pio_err_n      (pio_err_n),
        .spare_flt_n    (spare_flt_n),
        .bist_flt_n     (bist_flt_n),
        .bus_tmo        (bus_tmo),
        .suspend        (suspend),
        .set_vec        (set_vec),
        .abort_req      (abort_req)
    );

    fc_sticky_reg #(.W(FW)) u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr),
        .set_vec (set_vec),
        .q       (fault_reg)
    );

    fc_abort_pulse u_abort (
        .clk       (clk),
        .rst_n     (rst_n),
        .abort_req (abort_req),
        .suspend   (suspend),
        .abort_n   (abort_n)
    );

    // Purpose: report a stored address fault unless an acknowledge is present.
    always_comb begin
        illegal_addr_n = !((fault_reg[POS_IOADDR] || fault_reg[POS_MEMADDR]) && !suspend);
    end
endmodule

// File: rtl/fault_capture_chk.sv
// Module: fault_capture_chk
// Property checker for fault_capture, attached with bind. Observes ports only.
module fault_capture_chk #(
    parameter int FW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          gen_flt_n,
    input logic          ext_addr_err_n,
    input logic          bus_tmo,
    input logic          dma_ack_n,
    input logic          hold_ack_n,
    input logic          clr,
    input logic [FW-1:0] fault_reg,
    input logic          abort_n,
    input logic          illegal_addr_n
);
    logic susp;
    assign susp = !dma_ack_n || !hold_ack_n;

    AST_STICKY_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> ((fault_reg & $past(fault_reg)) == $past(fault_reg))); // R6

    AST_BIST_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        fault_reg[13] == fault_reg[15]); // R5

    AST_NO_ADDR_IN_SUSPEND: assert property (@(posedge clk) disable iff (!rst_n)
        (susp && !fault_reg[5] && !fault_reg[8]) |=> (!fault_reg[5] && !fault_reg[8])); // R8

    AST_ILLADDR_HIGH_SUSPEND: assert property (@(posedge clk) disable iff (!rst_n)
        susp |-> illegal_addr_n); // R9

    AST_ABORT_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        !abort_n |-> $past(!gen_flt_n || !ext_addr_err_n || bus_tmo, 2)); // R10

    AST_ABORT_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        $past(susp) |-> abort_n); // R11
endmodule

bind fault_capture fault_capture_chk #(.FW(FW)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .gen_flt_n      (gen_flt_n),
    .ext_addr_err_n (ext_addr_err_n),
    .bus_tmo        (bus_tmo),
    .dma_ack_n      (dma_ack_n),
    .hold_ack_n     (hold_ack_n),
    .clr            (clr),
    .fault_reg      (fault_reg),
    .abort_n        (abort_n),
    .illegal_addr_n (illegal_addr_n)
);

// File: tb/fault_capture_test.sv
module fault_capture_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        gen_flt_n = 1'b1, dma_par_err_n = 1'b1, ext_addr_err_n = 1'b1;
    logic        mem_cycle = 1'b0, pio_err_n = 1'b1, spare_flt_n = 1'b1;
    logic        bist_flt_n = 1'b1, bus_tmo = 1'b0;
    logic        dma_ack_n = 1'b1, hold_ack_n = 1'b1, clr = 1'b0;
    logic [15:0] fault_reg;
    logic        abort_n, illegal_addr_n;
    int          n_tests = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    fault_capture uut (
        .clk(clk), .rst_n(rst_n), .gen_flt_n(gen_flt_n), .dma_par_err_n(dma_par_err_n),
        .ext_addr_err_n(ext_addr_err_n), .mem_cycle(mem_cycle), .pio_err_n(pio_err_n),
        .spare_flt_n(spare_flt_n), .bist_flt_n(bist_flt_n), .bus_tmo(bus_tmo),
        .dma_ack_n(dma_ack_n), .hold_ack_n(hold_ack_n), .clr(clr),
        .fault_reg(fault_reg), .abort_n(abort_n), .illegal_addr_n(illegal_addr_n)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic idle();
        gen_flt_n = 1'b1; dma_par_err_n = 1'b1; ext_addr_err_n = 1'b1;
        pio_err_n = 1'b1; spare_flt_n = 1'b1; bist_flt_n = 1'b1;
        bus_tmo = 1'b0; clr = 1'b0;
    endtask

    task automatic drive_src(input int src);
        case (src)
            0: gen_flt_n = 1'b0;
            1: dma_par_err_n = 1'b0;
            2: ext_addr_err_n = 1'b0;
            3: pio_err_n = 1'b0;
            4: spare_flt_n = 1'b0;
            5: bist_flt_n = 1'b0;
            default: bus_tmo = 1'b1;
        endcase
    endtask

    function automatic string src_tag(input int src);
        case (src)
            0, 1, 3, 4: return "R2";
            2: return "R3";
            5: return "R5";
            default: return "R4";
        endcase
    endfunction

    // Watchdog: a hung run counts as a failed check and still prints the summary.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog act=hung exp=done");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        // R1: state after reset
        check("R1 fault_reg", 32'(fault_reg), 32'h0);
        check("R1 abort_n", 32'(abort_n), 32'h1);
        check("R1 illegal_addr_n", 32'(illegal_addr_n), 32'h1);
        rst_n = 1'b1;
        tick();

        // Sweep: every source, both qualifiers, all acknowledge combinations.
        for (int src = 0; src < 7; src++) begin
            for (int mem = 0; mem < 2; mem++) begin
                for (int sm = 0; sm < 4; sm++) begin
                    logic [15:0] exp;
                    logic        susp;
                    logic        exp_abort;
                    idle();
                    dma_ack_n  = !sm[0];
                    hold_ack_n = !sm[1];
                    susp = (sm != 0);
                    clr = 1'b1;
                    tick();
                    clr = 1'b0;
                    tick();
                    check("R6 cleared before trial", 32'(fault_reg), 32'h0);
                    mem_cycle = mem[0];
                    drive_src(src);
                    tick();
                    idle();
                    case (src)
                        0: exp = 16'h1 << 0;
                        1: exp = 16'h1 << 4;
                        3: exp = 16'h1 << 6;
                        4: exp = 16'h1 << 7;
                        5: exp = (16'h1 << 13) | (16'h1 << 15);
                        default: exp = susp ? 16'h0 : (16'h1 << (mem ? 8 : 5));
                    endcase
                    check(susp ? "R8 latch in suspend" : src_tag(src), 32'(fault_reg), 32'(exp));
                    check("R9 illegal_addr_n", 32'(illegal_addr_n),
                          32'(!((exp[5] || exp[8]) && !susp)));
                    exp_abort = (exp[0] || exp[5] || exp[8]) && !susp;
                    tick();
                    check(susp ? "R11 abort blocked" : "R10 abort low", 32'(abort_n), 32'(!exp_abort));
                    tick();
                    check("R10 abort one clock", 32'(abort_n), 32'h1);
                end
            end
        end
        dma_ack_n = 1'b1; hold_ack_n = 1'b1;
        clr = 1'b1; tick(); clr = 1'b0;

        // R6: stickiness and clear
        dma_par_err_n = 1'b0; tick(); dma_par_err_n = 1'b1;
        repeat (4) tick();
        check("R6 sticky", 32'(fault_reg), 32'h10);
        pio_err_n = 1'b0; tick(); pio_err_n = 1'b1;
        check("R6 accumulate", 32'(fault_reg), 32'h50);
        clr = 1'b1; tick(); clr = 1'b0;
        check("R6 clear", 32'(fault_reg), 32'h0);

        // R7: a set at the same edge as clear wins
        dma_par_err_n = 1'b0; tick(); dma_par_err_n = 1'b1;
        clr = 1'b1; spare_flt_n = 1'b0; tick(); clr = 1'b0; spare_flt_n = 1'b1;
        check("R7 set wins over clear", 32'(fault_reg), 32'h80);
        clr = 1'b1; tick(); clr = 1'b0;

        // R11: acknowledge present only at the edge that would start the abort
        gen_flt_n = 1'b0; tick(); gen_flt_n = 1'b1;
        check("R2 bit0 latched", 32'(fault_reg), 32'h1);
        dma_ack_n = 1'b0; tick(); dma_ack_n = 1'b1;
        check("R11 abort blocked at emit edge", 32'(abort_n), 32'h1);
        tick();
        check("R11 no late abort", 32'(abort_n), 32'h1);

        // R10: back-to-back causes give a two-clock low
        clr = 1'b1; tick(); clr = 1'b0;
        gen_flt_n = 1'b0; tick(); tick(); gen_flt_n = 1'b1;
        check("R10 first abort", 32'(abort_n), 32'h0);
        tick();
        check("R10 second abort", 32'(abort_n), 32'h0);
        tick();
        check("R10 abort ends", 32'(abort_n), 32'h1);

        // R9: an acknowledge arriving while an address bit is set
        clr = 1'b1; tick(); clr = 1'b0;
        mem_cycle = 1'b1; ext_addr_err_n = 1'b0; tick(); ext_addr_err_n = 1'b1;
        check("R3 memory bit", 32'(fault_reg), 32'h100);
        check("R9 indicator low", 32'(illegal_addr_n), 32'h0);
        hold_ack_n = 1'b0; #1;
        check("R9 forced high by hold", 32'(illegal_addr_n), 32'h1);
        hold_ack_n = 1'b1; #1;
        check("R9 low again", 32'(illegal_addr_n), 32'h0);
        tick();

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule